// File: doc/BRIEF.md
# Synchronous buck gate control logic

This block is the digital decision core of a half-bridge gate driver for a synchronous buck stage. Two comparator flags describe the analog PWM level: one says the input is above the upper threshold, the other says it is below the lower threshold. When neither flag is set, the input is in the middle window. From these flags the block derives the enables for the high-side and low-side gates. It inserts a dead time so that the two gates never conduct together. If the PWM source floats in the middle window for a hold-off time, the block recognises a high-impedance (tri-state) source and turns both gates off.

Several conditions can keep the bridge off: a run input, a supply undervoltage tracker with hysteresis, and an over-temperature shutdown. Each of them turns both gates off. A separate active-low input suppresses only the low-side gate, which is used for discontinuous-conduction operation. The die temperature arrives as an unsigned code in degrees Celsius. The block compares it against two hysteresis bands and produces an active-low warning, which is advisory only, and a shutdown pull-down request for the shared enable line. Every input passes through a two-flop synchroniser. Control and status pins are plain levels; there is no streaming data path, so there is no handshake.

Top module: `buck_gate_ctrl`

## Requirements
- R1: In normal operation, a valid high (`pwm_over_hi`=1) gives `hs_gate_en`=1 and `ls_gate_en`=0, and a valid low (`pwm_under_lo`=1) gives `hs_gate_en`=0 and `ls_gate_en`=1.
- R2: If both PWM flags stay 0 for HOLD_CYC consecutive synchronised cycles, both gates go low (tri-state). A middle-window stay of HOLD_CYC-1 cycles leaves the gate that was on undisturbed.
- R3: In tri-state, a valid low keeps both gates low. Only a valid high brings the block back to normal operation.
- R4: After reset both gates are low, and they remain low with PWM low until the first valid high.
- R5: With `ls_inhibit_n`=0 the low-side gate stays low while the high side still follows PWM. With `ls_inhibit_n`=1 the input has no effect.
- R6: Undervoltage is active after reset. It clears when `vsup_over_start`=1 and becomes active again only when `vsup_over_stop`=0. While it is active both gates are low and the block returns to tri-state, so operation after recovery needs a new valid high.
- R7: With `drv_run`=0 both gates are low. With `drv_run`=1 and no other blocking condition, the gates follow PWM.
- R8: Shutdown sets when `die_temp` > 150 and clears when `die_temp` < 135. While it is set, both gates are low and `shdn_pull`=1.
- R9: `hot_warn_n` goes to 0 when `die_temp` > 115 and returns to 1 when `die_temp` < 100. It never changes the gate enables.
- R10: `hs_gate_en` and `ls_gate_en` are never 1 together, and after a gate switches off both stay low for at least DEAD_CYC cycles before either one switches on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_over_hi | input | 1 | PWM above upper threshold (asynchronous) |
| pwm_under_lo | input | 1 | PWM below lower threshold (asynchronous) |
| drv_run | input | 1 | Run request; 0 (or a floating line) keeps both gates off |
| ls_inhibit_n | input | 1 | Active-low low-side suppression |
| vsup_over_start | input | 1 | Supply above the start threshold |
| vsup_over_stop | input | 1 | Supply above the lower shutdown threshold |
| die_temp | input | TEMP_W | Die temperature code, degrees Celsius, unsigned |
| hs_gate_en | output | 1 | High-side gate enable |
| ls_gate_en | output | 1 | Low-side gate enable |
| hot_warn_n | output | 1 | Active-low thermal warning (open-drain style) |
| shdn_pull | output | 1 | Pull-down request on the enable line during shutdown |

## Verification
Two functions can act in the same cycle: recovery from tri-state on a valid high, and the start of a thermal shutdown. The bench provokes this by moving PWM to a valid high and the temperature code above 150 in the same time step. It then judges that the high-side gate stays low and the pull-down is asserted for as long as shutdown holds. Once the temperature drops below the release point, the high side must come on without a fresh PWM edge, because the tri-state exit has already been taken.

// File: rtl/buck_gate_pkg.sv
package buck_gate_pkg;
  typedef enum logic {
    DEC_TRI = 1'b0,
    DEC_RUN = 1'b1
  } dec_state_e;
endpackage

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pwm_decoder.sv
module pwm_decoder
  import buck_gate_pkg::*;
#(
  parameter int HOLD_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi,
  input  logic lo,
  input  logic force_tri,
  output logic active,
  output logic cmd
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  dec_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DEC_TRI;
      cmd     <= 1'b0;
      cnt_q   <= '0;
    end else if (force_tri) begin
      state_q <= DEC_TRI;
      cmd     <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        DEC_TRI: begin
          cnt_q <= '0;
          if (hi) begin
            state_q <= DEC_RUN;
            cmd     <= 1'b1;
          end
        end
        default: begin
          if (hi) begin
            cmd   <= 1'b1;
            cnt_q <= '0;
          end else if (lo) begin
            cmd   <= 1'b0;
            cnt_q <= '0;
          end else if (cnt_q == LAST) begin
            state_q <= DEC_TRI;
            cmd     <= 1'b0;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign active = (state_q == DEC_RUN);

  // R3
  tri_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DEC_TRI && !hi) |=> (state_q == DEC_TRI));

  // R2
  hold_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DEC_RUN && (hi || lo) && !force_tri) |=> (state_q == DEC_RUN));
endmodule

// File: rtl/hyst_flag.sv
module hyst_flag #(
  parameter int W         = 8,
  parameter int SET_ABOVE = 150,
  parameter int CLR_BELOW = 135
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] val,
  output logic         flag
);
  localparam logic [W-1:0] SET_V = W'(SET_ABOVE);
  localparam logic [W-1:0] CLR_V = W'(CLR_BELOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag <= 1'b0;
    else if (val > SET_V)    flag <= 1'b1;
    else if (val < CLR_V)    flag <= 1'b0;
  end

  // R8 R9
  rise_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(val) > SET_V));

  // R8 R9
  fall_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(val) < CLR_V));
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer #(
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hs,
  input  logic want_ls,
  output logic hs_q,
  output logic ls_q
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

  logic [DW-1:0] dcnt_q;
  logic          gap_done;

  assign gap_done = (dcnt_q == DEAD_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      dcnt_q <= '0;
    end else begin
      if (hs_q || ls_q)   dcnt_q <= '0;
      else if (!gap_done) dcnt_q <= dcnt_q + 1'b1;

      if (hs_q)                          hs_q <= want_hs;
      else if (!ls_q && gap_done && want_hs) hs_q <= 1'b1;

      if (ls_q)                                     ls_q <= want_ls;
      else if (!hs_q && gap_done && want_ls && !want_hs) ls_q <= 1'b1;
    end
  end

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));

  // R10
  ls_off_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ls_q) |=> !hs_q);

  // R10
  hs_off_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_q) |=> !ls_q);
endmodule

// File: rtl/buck_gate_ctrl.sv
module buck_gate_ctrl #(
  parameter int TEMP_W   = 8,
  parameter int HOLD_CYC = 13,
  parameter int DEAD_CYC = 3,
  parameter int WARN_ON  = 115,
  parameter int WARN_OFF = 100,
  parameter int SD_ON    = 150,
  parameter int SD_OFF   = 135
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_over_hi,
  input  logic              pwm_under_lo,
  input  logic              drv_run,
  input  logic              ls_inhibit_n,
  input  logic              vsup_over_start,
  input  logic              vsup_over_stop,
  input  logic [TEMP_W-1:0] die_temp,
  output logic              hs_gate_en,
  output logic              ls_gate_en,
  output logic              hot_warn_n,
  output logic              shdn_pull
);
  localparam int SW = 6 + TEMP_W;

  logic [SW-1:0]     raw, syn;
  logic              s_hi, s_lo, s_run, s_lsinh_n, s_start, s_stop;
  logic [TEMP_W-1:0] s_temp;
  logic              uv_q, warn, shdn;
  logic              dec_active, dec_cmd, path_ok, want_hs, want_ls;

  assign raw = {pwm_over_hi, pwm_under_lo, drv_run, ls_inhibit_n,
                vsup_over_start, vsup_over_stop, die_temp};

  gate_sync #(.W(SW), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign {s_hi, s_lo, s_run, s_lsinh_n, s_start, s_stop, s_temp} = syn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       uv_q <= 1'b1;
    else if (s_start) uv_q <= 1'b0;
    else if (!s_stop) uv_q <= 1'b1;
  end

  pwm_decoder #(.HOLD_CYC(HOLD_CYC)) u_dec (
    .clk(clk), .rst_n(rst_n), .hi(s_hi), .lo(s_lo), .force_tri(uv_q),
    .active(dec_active), .cmd(dec_cmd)
  );

  hyst_flag #(.W(TEMP_W), .SET_ABOVE(WARN_ON), .CLR_BELOW(WARN_OFF)) u_warn (
    .clk(clk), .rst_n(rst_n), .val(s_temp), .flag(warn)
  );

  hyst_flag #(.W(TEMP_W), .SET_ABOVE(SD_ON), .CLR_BELOW(SD_OFF)) u_shdn (
    .clk(clk), .rst_n(rst_n), .val(s_temp), .flag(shdn)
  );

  assign path_ok = dec_active && s_run && !uv_q && !shdn;
  assign want_hs = path_ok && dec_cmd;
  assign want_ls = path_ok && !dec_cmd && s_lsinh_n;

  gate_sequencer #(.DEAD_CYC(DEAD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .want_hs(want_hs), .want_ls(want_ls),
    .hs_q(hs_gate_en), .ls_q(ls_gate_en)
  );

  assign hot_warn_n = !warn;
  assign shdn_pull  = shdn;

  // R8
  shdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shdn |=> (!hs_gate_en && !ls_gate_en));

  // R6
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_q |=> (!hs_gate_en && !ls_gate_en));

  // R7
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_run |=> (!hs_gate_en && !ls_gate_en));

  // R5
  ls_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_lsinh_n |=> !ls_gate_en);
endmodule

// File: tb/buck_gate_ctrl_bench.sv
module buck_gate_ctrl_bench;
  localparam int TEMP_W   = 8;
  localparam int HOLD_CYC = 13;
  localparam int DEAD_CYC = 3;
  localparam int SETTLE   = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_over_hi = 1'b0, pwm_under_lo = 1'b1, drv_run = 1'b1;
  logic ls_inhibit_n = 1'b1, vsup_over_start = 1'b1, vsup_over_stop = 1'b1;
  logic [TEMP_W-1:0] die_temp = 8'd25;
  logic hs_gate_en, ls_gate_en, hot_warn_n, shdn_pull;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  buck_gate_ctrl #(.TEMP_W(TEMP_W), .HOLD_CYC(HOLD_CYC), .DEAD_CYC(DEAD_CYC)) u_buck_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_over_hi(pwm_over_hi), .pwm_under_lo(pwm_under_lo),
    .drv_run(drv_run), .ls_inhibit_n(ls_inhibit_n), .vsup_over_start(vsup_over_start),
    .vsup_over_stop(vsup_over_stop), .die_temp(die_temp), .hs_gate_en(hs_gate_en),
    .ls_gate_en(ls_gate_en), .hot_warn_n(hot_warn_n), .shdn_pull(shdn_pull)
  );

  // dead-time / overlap monitor (R10)
  int  low_run = 100;
  logic prev_low = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (hs_gate_en && ls_gate_en) begin
        checks++; fails++;
        $display("FAIL R10: overlap hs=1 ls=1 expected at most one high");
      end
      if (prev_low && (hs_gate_en || ls_gate_en)) begin
        checks++;
        if (low_run < DEAD_CYC) begin
          fails++;
          $display("FAIL R10: dead gap %0d cycles, expected >= %0d", low_run, DEAD_CYC);
        end
      end
      prev_low = !hs_gate_en && !ls_gate_en;
      low_run  = prev_low ? low_run + 1 : 0;
    end
  end

  task automatic gates(string tag, logic eh, logic el);
    checks++;
    if (hs_gate_en !== eh || ls_gate_en !== el) begin
      fails++;
      $display("FAIL %s: hs/ls=%b%b expected %b%b", tag, hs_gate_en, ls_gate_en, eh, el);
    end
  endtask

  task automatic bitchk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // 2 = valid high, 1 = middle window, 0 = valid low
  task automatic pwm(int lvl);
    @(negedge clk);
    pwm_over_hi  = (lvl == 2);
    pwm_under_lo = (lvl == 0);
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    gates("R4 reset", 1'b0, 1'b0);
    bitchk("R9 reset warn", hot_warn_n, 1'b1);
    bitchk("R8 reset pull", shdn_pull, 1'b0);
    rst_n = 1'b1;
    settle();
    gates("R4 low before first high", 1'b0, 1'b0);
  endtask

  task automatic t_basic();
    pwm(2); settle(); gates("R1 high", 1'b1, 1'b0);
    pwm(0); settle(); gates("R1 low", 1'b0, 1'b1);
    pwm(2); settle(); gates("R1 high again", 1'b1, 1'b0);
  endtask

  task automatic t_short_mid();
    int drops = 0;
    pwm(0); settle();
    pwm(1);
    for (int i = 0; i < HOLD_CYC + 8; i++) begin
      if (i == HOLD_CYC - 2) begin pwm_under_lo = 1'b1; end
      @(negedge clk);
      if (!ls_gate_en) drops++;
    end
    checks++;
    if (drops != 0) begin
      fails++;
      $display("FAIL R2 short window: ls dropped %0d cycles expected 0", drops);
    end
  endtask

  task automatic t_tristate();
    pwm(1); repeat (HOLD_CYC + 10) @(negedge clk);
    gates("R2 tri-state", 1'b0, 1'b0);
    pwm(0); settle(); gates("R3 low stays off", 1'b0, 1'b0);
    pwm(2); settle(); gates("R3 high exits", 1'b1, 1'b0);
  endtask

  task automatic t_ls_inhibit();
    @(negedge clk); ls_inhibit_n = 1'b0;
    pwm(0); settle(); gates("R5 ls held off", 1'b0, 1'b0);
    pwm(2); settle(); gates("R5 hs still switches", 1'b1, 1'b0);
    pwm(0); settle(); gates("R5 ls off again", 1'b0, 1'b0);
    @(negedge clk); ls_inhibit_n = 1'b1;
    settle(); gates("R5 released", 1'b0, 1'b1);
  endtask

  task automatic t_uv();
    @(negedge clk); vsup_over_start = 1'b0;
    settle(); gates("R6 inside hysteresis", 1'b0, 1'b1);
    @(negedge clk); vsup_over_stop = 1'b0;
    settle(); gates("R6 undervoltage", 1'b0, 1'b0);
    @(negedge clk); vsup_over_stop = 1'b1;
    settle(); gates("R6 no early release", 1'b0, 1'b0);
    @(negedge clk); vsup_over_start = 1'b1;
    settle(); gates("R6 tri after recovery", 1'b0, 1'b0);
    pwm(2); settle(); gates("R6 high resumes", 1'b1, 1'b0);
  endtask

  task automatic t_run();
    @(negedge clk); drv_run = 1'b0;
    settle(); gates("R7 run low", 1'b0, 1'b0);
    @(negedge clk); drv_run = 1'b1;
    settle(); gates("R7 run high", 1'b1, 1'b0);
  endtask

  task automatic t_thermal();
    @(negedge clk); die_temp = 8'd115; settle();
    bitchk("R9 at 115 no warn", hot_warn_n, 1'b1);
    @(negedge clk); die_temp = 8'd116; settle();
    bitchk("R9 warn above 115", hot_warn_n, 1'b0);
    gates("R9 warn keeps gates", 1'b1, 1'b0);
    @(negedge clk); die_temp = 8'd150; settle();
    bitchk("R8 at 150 no shutdown", shdn_pull, 1'b0);
    @(negedge clk); die_temp = 8'd151; settle();
    bitchk("R8 shutdown pull", shdn_pull, 1'b1);
    gates("R8 shutdown gates", 1'b0, 1'b0);
    @(negedge clk); die_temp = 8'd135; settle();
    bitchk("R8 hold at 135", shdn_pull, 1'b1);
    @(negedge clk); die_temp = 8'd134; settle();
    bitchk("R8 release", shdn_pull, 1'b0);
    gates("R8 gates back", 1'b1, 1'b0);
    @(negedge clk); die_temp = 8'd100; settle();
    bitchk("R9 hold at 100", hot_warn_n, 1'b0);
    @(negedge clk); die_temp = 8'd99; settle();
    bitchk("R9 clear", hot_warn_n, 1'b1);
  endtask

  task automatic t_concurrent();
    pwm(1); repeat (HOLD_CYC + 10) @(negedge clk);
    gates("R2 tri before collision", 1'b0, 1'b0);
    @(negedge clk);
    pwm_over_hi = 1'b1; pwm_under_lo = 1'b0; die_temp = 8'd160;
    settle();
    gates("R8 shutdown wins over exit", 1'b0, 1'b0);
    bitchk("R8 pull in collision", shdn_pull, 1'b1);
    @(negedge clk); die_temp = 8'd120; settle();
    gates("R3 exit kept after shutdown", 1'b1, 1'b0);
    pwm(0); settle(); gates("R10 final low", 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_short_mid();
    t_tristate();
    t_ls_inhibit();
    t_uv();
    t_run();
    t_thermal();
    t_concurrent();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule